// File: doc/BRIEF.md
# Interlaced VSYNC Regenerator

This block produces a correct vertical sync for interlaced video. The timing engine feeding it drives correct pixels, line sync and data-enable, but its own vertical sync is wrong in interlaced modes. The block watches two of the engine's outputs, line sync (HSYNC) and data-enable (DE), and builds a new VSYNC from them. Both inputs pass through two-flop synchronizers into the sampling clock. A tick generator then marks every half-line: one tick just after each active HSYNC edge, and a second tick a programmed number of sampling cycles later. Software sets that delay to htotal × f_sample / (2 × f_pixel).

A sequencer follows the frame. It waits for DE, tracks the active region, and counts half-line ticks through the vertical front porch. It then holds VSYNC for the programmed number of half-lines and counts the back porch. At the end it samples DE to decide which of two per-field parameter sets applies next. The per-field sets are derived from four mode values: active lines, sync start line, sync end line and total lines. Polarities of HSYNC, DE and VSYNC are each selectable. When the board does not route DE to the block, the output stays at its inactive level.

Top module: `ilv_vsync_regen`

## Requirements
- R1: The half-line delay is counted from the sampling-clock cycle in which the synchronized HSYNC becomes active, which is two cycles after the input edge. One half-line tick fires in that cycle and a second fires `half_line_dly` cycles later. With a delay of half a line, the ticks are evenly spaced.
- R2: `hsync_neg` = 1 makes a low level on `hsync_in` the active HSYNC level; 0 makes high the active level.
- R3: After waiting for DE to become active, the sequencer stays in the active region until the first mid-line tick at which DE is inactive. That tick is half-line tick 0 of the blanking interval.
- R4: Before the porches are derived, the active line count is rounded down to even and the total line count is rounded up to odd. The front porch is sync start minus the rounded active count, and the back porch is the rounded total minus sync end, with a floor of zero.
- R5: The front porch is clamped to 3..128 half-lines. Any excess above 128 is added to the back porch. Any shortfall below 3 is taken from the back porch, down to a floor of zero.
- R6: With the first parameter set and clamped front porch F, VSYNC becomes active one cycle after half-line tick F−1. When the parity flag of the set in use is 0 (F even for the first set), VSYNC may only start on an HSYNC tick. When the flag is 1, any tick may start it.
- R7: VSYNC stays active for max(1, sync end − sync start) half-line ticks. It becomes inactive one cycle after the last of them.
- R8: The second parameter set has a front-porch count one lower, the opposite parity flag and a back porch one higher. With it, VSYNC starts one cycle after tick F−2.
- R9: After the back-porch ticks, DE is sampled once. If DE is active, the next field uses the first set. If DE is inactive, the next field uses the other set from the one just used.
- R10: `de_neg` = 1 makes a low `de_in` the active DE level. `vsync_neg` = 1 makes the VSYNC pulse drive `vsync_out` low, with high as the idle level.
- R11: While `de_present` is 0, `vsync_out` holds its inactive level from the next cycle on. Re-enabling the block restarts it in the first parameter set.
- R12: After reset with `vsync_neg` = 0, `vsync_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| de_present | input | 1 | DE is routed to the block; 0 disables it |
| hsync_in | input | 1 | Line sync from the timing engine (asynchronous) |
| de_in | input | 1 | Data-enable from the timing engine (asynchronous) |
| hsync_neg | input | 1 | HSYNC is active low |
| de_neg | input | 1 | DE is active low |
| vsync_neg | input | 1 | Output VSYNC is active low |
| half_line_dly | input | HDLY_W | Half-line delay in sampling-clock cycles |
| act_lines | input | LINE_W | Active lines of the frame |
| vs_start_line | input | LINE_W | Line where VSYNC starts |
| vs_end_line | input | LINE_W | Line where VSYNC ends |
| total_lines | input | LINE_W | Total lines of the frame |
| vsync_out | output | 1 | Regenerated VSYNC |

## Verification
Some rules hold on every cycle, and the assertions check those. Each VSYNC edge must fall on a half-line tick, and the start must be on an HSYNC tick when the parity flag is clear. The derived front-porch count must stay inside its clamp range. The two sets must carry opposite parity flags, and disabling the block must force the idle level. Other behaviour only shows up over whole fields, so the bench's directed scenarios cover it. Those scenarios measure the exact half-line position and width of the pulse, and the alternation and reset of field phase from the DE sample. They also cover the rounding of line counts and the redistribution of a clamped front porch into the back porch, seen through its effect on the next field.

// File: rtl/ilv_pkg.sv
`timescale 1ns/1ps
package ilv_pkg;

    localparam int CNT_W  = 16;   // half-line counter width
    localparam int FP_MIN = 3;    // smallest front porch in half-lines
    localparam int FP_MAX = 128;  // largest front porch in half-lines

    typedef enum logic [2:0] {
        S_WAIT_DE,
        S_ACTIVE,
        S_FP,
        S_ALIGN,
        S_SYNC,
        S_BP,
        S_PHASE
    } seq_state_e;

    // One field's blanking recipe
    typedef struct packed {
        logic [CNT_W-1:0] fp_cnt;     // half-line ticks to skip before alignment
        logic             align_any;  // 1: any tick starts VSYNC, 0: HSYNC tick only
        logic [CNT_W-1:0] bp_cnt;     // half-line ticks after VSYNC
    } field_set_t;

    typedef struct packed {
        field_set_t       first;
        field_set_t       second;
        logic [CNT_W-1:0] sync_len;   // VSYNC width in half-line ticks
    } field_plan_t;

    function automatic field_plan_t plan_fields(
        input logic [CNT_W-1:0] act,
        input logic [CNT_W-1:0] vs_start,
        input logic [CNT_W-1:0] vs_end,
        input logic [CNT_W-1:0] total
    );
        int fp;
        int bp;
        int sl;
        field_plan_t p;
        fp = int'(vs_start) - int'(act & ~CNT_W'(1));
        bp = int'(total | CNT_W'(1)) - int'(vs_end);
        if (bp < 0) bp = 0;
        if (fp > FP_MAX) begin
            bp = bp + (fp - FP_MAX);
            fp = FP_MAX;
        end else if (fp < FP_MIN) begin
            bp = (bp > (FP_MIN - fp)) ? bp - (FP_MIN - fp) : 0;
            fp = FP_MIN;
        end
        sl = int'(vs_end) - int'(vs_start);
        if (sl < 1) sl = 1;
        p.first.fp_cnt     = CNT_W'(fp - 2);
        p.first.align_any  = fp[0];
        p.first.bp_cnt     = CNT_W'(bp);
        p.second.fp_cnt    = CNT_W'(fp - 3);
        p.second.align_any = ~fp[0];
        p.second.bp_cnt    = CNT_W'(bp + 1);
        p.sync_len         = CNT_W'(sl);
        return p;
    endfunction

endpackage

// File: rtl/ilv_sync2.sv
`timescale 1ns/1ps
module ilv_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;
    logic [W-1:0] s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
        end else begin
            s1 <= d;
            s2 <= s1;
        end
    end

    assign q = s2;
endmodule

// File: rtl/ilv_tick_gen.sv
`timescale 1ns/1ps
module ilv_tick_gen #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hs_act,     // synchronized, polarity-corrected HSYNC
    input  logic [DW-1:0] half_dly,
    output logic          tick_hs,
    output logic          tick_mid
);
    logic          hs_d;
    logic [DW-1:0] cnt;

    assign tick_hs  = hs_act & ~hs_d;
    assign tick_mid = (cnt == DW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_d <= 1'b0;
            cnt  <= '0;
        end else begin
            hs_d <= hs_act;
            if (tick_hs)
                cnt <= half_dly;
            else if (cnt != '0)
                cnt <= cnt - DW'(1);
        end
    end
endmodule

// File: rtl/ilv_field_seq.sv
`timescale 1ns/1ps
module ilv_field_seq
    import ilv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  logic        tick_hs,
    input  logic        tick_mid,
    input  logic        de_act,
    input  field_plan_t plan,
    output logic        vs_act,
    output logic        field_b
);
    seq_state_e       st;
    logic [CNT_W-1:0] cnt;
    field_set_t       cur;
    logic             tick;

    assign cur  = field_b ? plan.second : plan.first;
    assign tick = tick_hs | tick_mid;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            st      <= S_WAIT_DE;
            cnt     <= '0;
            vs_act  <= 1'b0;
            field_b <= 1'b0;
        end else begin
            case (st)
                S_WAIT_DE: if (de_act) st <= S_ACTIVE;
                S_ACTIVE: begin
                    if (tick_mid && !de_act) begin
                        st  <= S_FP;
                        cnt <= cur.fp_cnt;
                    end
                end
                S_FP: begin
                    if (cnt == '0)
                        st <= S_ALIGN;
                    else if (tick)
                        cnt <= cnt - CNT_W'(1);
                end
                S_ALIGN: begin
                    if (tick_hs || (tick_mid && cur.align_any)) begin
                        st     <= S_SYNC;
                        vs_act <= 1'b1;
                        cnt    <= plan.sync_len;
                    end
                end
                S_SYNC: begin
                    if (tick) begin
                        if (cnt <= CNT_W'(1)) begin
                            st     <= S_BP;
                            vs_act <= 1'b0;
                            cnt    <= cur.bp_cnt;
                        end else begin
                            cnt <= cnt - CNT_W'(1);
                        end
                    end
                end
                S_BP: begin
                    if (cnt == '0)
                        st <= S_PHASE;
                    else if (tick)
                        cnt <= cnt - CNT_W'(1);
                end
                S_PHASE: begin
                    field_b <= de_act ? 1'b0 : ~field_b;
                    st      <= S_WAIT_DE;
                end
                default: st <= S_WAIT_DE;
            endcase
        end
    end
endmodule

// File: rtl/ilv_vsync_regen.sv
`timescale 1ns/1ps
module ilv_vsync_regen
    import ilv_pkg::*;
#(
    parameter int LINE_W = 12,
    parameter int HDLY_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              de_present,
    input  logic              hsync_in,
    input  logic              de_in,
    input  logic              hsync_neg,
    input  logic              de_neg,
    input  logic              vsync_neg,
    input  logic [HDLY_W-1:0] half_line_dly,
    input  logic [LINE_W-1:0] act_lines,
    input  logic [LINE_W-1:0] vs_start_line,
    input  logic [LINE_W-1:0] vs_end_line,
    input  logic [LINE_W-1:0] total_lines,
    output logic              vsync_out
);
    logic [1:0]  raw_in;
    logic [1:0]  sync_in;
    logic        hs_act;
    logic        de_act;
    logic        tick_hs;
    logic        tick_mid;
    logic        vs_act;
    logic        field_b;
    field_plan_t plan;

    assign raw_in = {hsync_in, de_in};
    assign hs_act = sync_in[1] ^ hsync_neg;
    assign de_act = sync_in[0] ^ de_neg;
    assign plan   = plan_fields(CNT_W'(act_lines), CNT_W'(vs_start_line),
                                CNT_W'(vs_end_line), CNT_W'(total_lines));

    ilv_sync2 #(.W(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_in)
    );

    ilv_tick_gen #(.DW(HDLY_W)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .hs_act   (hs_act),
        .half_dly (half_line_dly),
        .tick_hs  (tick_hs),
        .tick_mid (tick_mid)
    );

    ilv_field_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .enable   (de_present),
        .tick_hs  (tick_hs),
        .tick_mid (tick_mid),
        .de_act   (de_act),
        .plan     (plan),
        .vs_act   (vs_act),
        .field_b  (field_b)
    );

    assign vsync_out = vs_act ^ vsync_neg;
endmodule

// File: rtl/ilv_vsync_regen_chk.sv
`timescale 1ns/1ps
module ilv_vsync_regen_chk
    import ilv_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             de_present,
    input logic             vsync_neg,
    input logic             vsync_out,
    input logic             tick_hs,
    input logic             tick_mid,
    input logic             vs_act,
    input logic             field_b,
    input logic             a_any,
    input logic             b_any,
    input logic [CNT_W-1:0] a_fp
);
    logic past_ok;
    logic cur_any;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    assign cur_any = field_b ? b_any : a_any;

    assert_tick_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        tick_hs |=> !tick_hs);

    assert_fp_range_R5: assert property (@(posedge clk) disable iff (rst)
        (a_fp >= CNT_W'(1)) && (a_fp <= CNT_W'(126)));

    assert_vs_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $rose(vs_act)) |-> ($past(tick_hs) || $past(tick_mid)));

    assert_aligned_start_R6: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $rose(vs_act) && !$past(cur_any)) |-> $past(tick_hs));

    assert_vs_end_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $fell(vs_act) && $past(de_present)) |-> ($past(tick_hs) || $past(tick_mid)));

    assert_opposite_parity_R8: assert property (@(posedge clk) disable iff (rst)
        a_any != b_any);

    assert_disabled_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !de_present |=> (vsync_out == vsync_neg));
endmodule

bind ilv_vsync_regen ilv_vsync_regen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .de_present (de_present),
    .vsync_neg  (vsync_neg),
    .vsync_out  (vsync_out),
    .tick_hs    (tick_hs),
    .tick_mid   (tick_mid),
    .vs_act     (vs_act),
    .field_b    (field_b),
    .a_any      (plan.first.align_any),
    .b_any      (plan.second.align_any),
    .a_fp       (plan.first.fp_cnt)
);

// File: tb/sim_ilv_vsync_regen.sv
`timescale 1ns/1ps
module sim_ilv_vsync_regen;
    localparam int HT      = 40;   // line length in sampling cycles
    localparam int HS_LEN  = 4;
    localparam int DE_FROM = 8;
    localparam int DE_TO   = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        de_present = 1'b0;
    logic        hsync_in = 1'b0;
    logic        de_in = 1'b0;
    logic        hsync_neg = 1'b0;
    logic        de_neg = 1'b0;
    logic        vsync_neg = 1'b0;
    logic [15:0] half_line_dly = 16'(HT / 2);
    logic [11:0] act_lines = '0;
    logic [11:0] vs_start_line = '0;
    logic [11:0] vs_end_line = '0;
    logic [11:0] total_lines = '0;
    logic        vsync_out;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    ilv_vsync_regen u0 (
        .clk           (clk),
        .rst           (rst),
        .de_present    (de_present),
        .hsync_in      (hsync_in),
        .de_in         (de_in),
        .hsync_neg     (hsync_neg),
        .de_neg        (de_neg),
        .vsync_neg     (vsync_neg),
        .half_line_dly (half_line_dly),
        .act_lines     (act_lines),
        .vs_start_line (vs_start_line),
        .vs_end_line   (vs_end_line),
        .total_lines   (total_lines),
        .vsync_out     (vsync_out)
    );

    task automatic chk(input string tag, input int actual, input int expected);
        tests++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    // Drive one field; report VSYNC rise/fall cycles relative to the first blank line
    task automatic run_field(input int n_act, input int n_blank, output int rise, output int fall);
        int  c;
        bit  prev;
        bit  cur;
        rise = -1;
        fall = -1;
        prev = 1'b0;
        c    = 0;
        for (int ln = 0; ln < n_act + n_blank; ln++) begin
            for (int j = 0; j < HT; j++) begin
                @(negedge clk);
                cur = vsync_out ^ vsync_neg;
                if (cur && !prev && rise < 0)
                    rise = c - n_act * HT;
                else if (!cur && prev && rise >= 0 && fall < 0)
                    fall = c - n_act * HT;
                prev = cur;
                hsync_in = (j < HS_LEN) ^ hsync_neg;
                de_in    = ((ln < n_act) && (j >= DE_FROM) && (j < DE_TO)) ^ de_neg;
                c++;
            end
        end
    endtask

    task automatic field_expect(input string tag, input int n_act, input int n_blank,
                                input int exp_rise, input int exp_fall);
        int r;
        int f;
        run_field(n_act, n_blank, r, f);
        chk({tag, " rise"}, r, exp_rise);
        chk({tag, " fall"}, f, exp_fall);
    endtask

    task automatic restart(input int a, input int vss, input int vse, input int tot,
                           input bit hn, input bit dn, input bit vn);
        int r;
        int f;
        de_present    = 1'b0;
        act_lines     = 12'(a);
        vs_start_line = 12'(vss);
        vs_end_line   = 12'(vse);
        total_lines   = 12'(tot);
        hsync_neg     = hn;
        de_neg        = dn;
        vsync_neg     = vn;
        run_field(0, 2, r, f);
        de_present = 1'b1;
        run_field(0, 1, r, f);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R12 idle after reset", int'(vsync_out), 0);
    endtask

    // F=5, sync 3, bp 7: first set rises at 3+20*5, second one half-line earlier
    task automatic t_alternate;
        restart(8, 13, 16, 23, 1'b0, 1'b0, 1'b0);
        field_expect("R1 R3 R6 R7 first set", 4, 8, 103, 163);
        field_expect("R8 R9 toggled to second set", 4, 7, 83, 143);
        field_expect("R9 DE active resets to first set", 4, 8, 103, 163);
        field_expect("R8 second set again", 4, 8, 83, 143);
        field_expect("R9 inactive DE after second set returns to first", 4, 7, 103, 163);
        field_expect("R9 DE active keeps first set", 4, 8, 103, 163);
    endtask

    task automatic t_polarity;
        restart(8, 13, 16, 23, 1'b1, 1'b1, 1'b1);
        field_expect("R2 R10 inverted polarities", 4, 8, 103, 163);
        chk("R10 idle level high", int'(vsync_out), 1);
    endtask

    task automatic t_disabled;
        int r;
        int f;
        restart(8, 13, 16, 23, 1'b0, 1'b0, 1'b1);
        de_present = 1'b0;
        run_field(4, 8, r, f);
        chk("R11 no pulse while disabled", r, -1);
        chk("R11 output held inactive", int'(vsync_out), 1);
        vsync_neg = 1'b0;
        run_field(4, 8, r, f);
        chk("R11 no pulse while disabled, active-high", r, -1);
    endtask

    // act 9 -> 8, total 22 -> 23: F=4 (rise 83), back porch ends mid-line in next field
    task automatic t_round;
        restart(9, 12, 14, 22, 1'b0, 1'b0, 1'b0);
        field_expect("R4 active count rounded down", 4, 7, 83, 123);
        field_expect("R4 total rounded up keeps first set", 4, 8, 83, 123);
    endtask

    // F=140 clamps to 128; 12 excess half-lines move into the back porch
    task automatic t_clamp_hi;
        restart(8, 148, 150, 153, 1'b0, 1'b0, 0);
        field_expect("R5 front porch clamped to 128", 4, 72, 2563, 2603);
        field_expect("R5 excess moved to back porch", 4, 72, 2563, 2603);
    endtask

    // F=1 raised to 3, back porch 12 -> 10
    task automatic t_clamp_lo;
        restart(8, 9, 11, 23, 1'b0, 1'b0, 1'b0);
        field_expect("R5 front porch raised to 3", 4, 8, 63, 103);
        field_expect("R5 R8 shortfall taken from back porch", 4, 8, 43, 83);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_alternate();
        t_polarity();
        t_disabled();
        t_round();
        t_clamp_hi();
        t_clamp_lo();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule